// File: doc/BRIEF.md
# Latched-Address Bytewide Nonvolatile RAM Controller

This block is a clock-domain model of the control path behind a bytewide nonvolatile RAM. The RAM is driven from an asynchronous-style parallel bus with three active-low strobes: chip select, write strobe and output enable. The strobes and the address and data buses first pass through a two-stage synchronizer, and the edges are detected on the synchronized copies. A memory cycle starts only when chip select falls. The address is captured at that moment, and the level of the write strobe at the same moment marks the cycle as a write. Otherwise the cycle opens as a read, which a later fall of the write strobe can turn into a write.

Each cycle runs a fixed access phase of `ACCESS_CYC` clocks. The phase runs to the end even if chip select is released early. After it comes a precharge phase that starts when chip select rises and lasts at least `PRECH_CYC` clocks. During precharge a new falling edge of chip select is ignored, and a sticky error flag is set. Read data reaches the output only after the access phase has completed. A write commits on the first release of either the write strobe or chip select, and no busy period follows it. The byte array is a register array that is zero at start-up and is never cleared by reset. Real pads are replaced by a drive-enable output. The default depth is reduced. Setting `ADDR_W` to 15 gives the full 32,768-byte part.

States: `ST_IDLE` (waiting for a chip-select fall), `ST_ACCESS` (internal access running), `ST_READY` (access done, chip select still held), `ST_PRECH` (precharge running). Transitions: IDLE→ACCESS on an accepted chip-select fall. ACCESS→READY when the access count ends with chip select still low. ACCESS→PRECH when the access count ends after chip select has risen. READY→PRECH on a chip-select rise. PRECH→IDLE once the precharge minimum is met.

Top module: `latram_ctrl`

## Requirements
- R1: The address is taken from `addr` only at an accepted chip-select fall. Changes to `addr` after that edge do not affect the cycle.
- R2: If `we_n` is low when chip select falls, the cycle is a write, and `rdata_en` stays 0 throughout the cycle whatever the level of `oe_n`.
- R3: If `we_n` is high at the chip-select fall, the cycle is a read and drives data according to `oe_n`. A later fall of `we_n` turns `rdata_en` off from the third rising clock edge after it, and the cycle becomes a write.
- R4: A write stores `wdata` into the latched address at the first rise of either `we_n` or `ce_n`, using the byte present on `wdata` at that rise. Later changes to `wdata` are not stored.
- R5: Inputs change between clock edges. `rdata_en` stays 0 until the access phase is complete. It first reads 1 after the (`ACCESS_CYC`+3)-th rising edge that follows the chip-select fall, and `rdata` then holds the addressed byte.
- R6: While `oe_n` is high, `rdata_en` is 0.
- R7: If chip select rises before the access phase ends, the cycle still finishes internally, and a write cycle stores its byte.
- R8: A chip-select fall is accepted only from the idle state, which requires chip select to have been high for at least `PRECH_CYC` clocks and the access phase to be over. A fall at any other time is ignored: no data is driven. It also sets `prech_err` to 1, which stays 1 until reset.
- R9: A read that starts right after the minimum precharge that follows a write returns the newly written byte. No busy or polling delay is needed.
- R10: The array reads as zero at start-up, and its contents survive an assertion of `rst_n`.
- R11: Under reset, `rdata_en` and `prech_err` are 0 and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control logic (not the array) |
| ce_n | input | 1 | Active-low chip select; its fall starts a cycle |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address, latched at the chip-select fall |
| wdata | input | DATA_W | Write data bus |
| rdata | output | DATA_W | Read data |
| rdata_en | output | 1 | Drive enable standing in for the tri-state data pads |
| prech_err | output | 1 | Sticky flag: a chip-select fall arrived outside the idle state |

## Verification
Every strobe change reaches the controller on the third rising edge after it is driven: two synchronizer stages, then the edge register. Read data is therefore due after edge `ACCESS_CYC`+3, and the write-strobe cut-off is due after edge 3. The bench drives and samples on falling edges and counts falling edges from each stimulus. It checks `rdata_en` low one falling edge before the due point and high at the due point. Precharge spacing is exercised at exactly `PRECH_CYC` falling edges, which must be accepted, and at one fewer, which must be rejected. Write data is checked by reading it back after the commit edge, once `wdata` has been changed again.

// File: rtl/latram_pkg.sv
package latram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_READY,
        ST_PRECH
    } cyc_state_e;

endpackage

// File: rtl/latram_sync.sv
module latram_sync #(
    parameter int STAGES = 2,
    parameter int BUS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       ctl_n_raw,
    input  logic [BUS_W-1:0] bus_raw,
    output logic [2:0]       ctl_n_s,
    output logic [1:0]       ctl_fall,
    output logic [1:0]       ctl_rise,
    output logic [BUS_W-1:0] bus_s
);

    localparam int EDGE_CH = 2;

    // level synchronizers for all three strobes (0: select, 1: write, 2: output)
    for (genvar ch = 0; ch < 3; ch++) begin : g_lvl
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[STAGES-2:0], ctl_n_raw[ch]};
        end
        assign ctl_n_s[ch] = sh[STAGES-1];
    end

    // edge detection only on the strobes whose edges matter
    for (genvar ch = 0; ch < EDGE_CH; ch++) begin : g_edge
        logic prev;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= 1'b1;
            else        prev <= ctl_n_s[ch];
        end
        assign ctl_fall[ch] = prev & ~ctl_n_s[ch];
        assign ctl_rise[ch] = ~prev & ctl_n_s[ch];
    end

    // address and data travel through the same depth so they line up with the strobes
    logic [BUS_W-1:0] bus_pipe [STAGES];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) bus_pipe[s] <= '0;
        end else begin
            bus_pipe[0] <= bus_raw;
            for (int s = 1; s < STAGES; s++) bus_pipe[s] <= bus_pipe[s-1];
        end
    end
    assign bus_s = bus_pipe[STAGES-1];

endmodule

// File: rtl/latram_array.sv
module latram_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // power-up contents only; no reset path reaches the storage
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/latram_fsm.sv
module latram_fsm
    import latram_pkg::*;
#(
    parameter int AW         = 10,
    parameter int DW         = 8,
    parameter int ACCESS_CYC = 4,
    parameter int PRECH_CYC  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          ce_fall,
    input  logic          ce_rise,
    input  logic          we_s,
    input  logic          we_fall,
    input  logic          we_rise,
    input  logic          oe_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] rd_word,
    output cyc_state_e    state,
    output logic [AW-1:0] lat_addr,
    output logic          wr_en,
    output logic          wr_mode,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive,
    output logic          prech_err
);

    localparam int ACW = $clog2(ACCESS_CYC + 1);
    localparam int PCW = $clog2(PRECH_CYC + 1);
    localparam logic [ACW-1:0] ACC_LAST = ACW'(ACCESS_CYC - 1);
    localparam logic [PCW-1:0] PC_MAX   = PCW'(PRECH_CYC);
    localparam logic [PCW-1:0] PC_EXIT  = PCW'(PRECH_CYC - 1);

    cyc_state_e     state_q, state_d;
    logic [ACW-1:0] acc_cnt;
    logic [PCW-1:0] pc_cnt;
    logic           wr_mode_q, wr_done_q, ce_up_q, err_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  rd_q;
    logic           cyc_open;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ce_fall) state_d = ST_ACCESS;
            ST_ACCESS: if (acc_cnt == ACC_LAST)
                           state_d = (ce_up_q || ce_rise) ? ST_PRECH : ST_READY;
            ST_READY:  if (ce_rise) state_d = ST_PRECH;
            ST_PRECH:  if (pc_cnt >= PC_EXIT) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cyc_open = (state_q == ST_ACCESS || state_q == ST_READY) && !ce_up_q;
        wr_en    = cyc_open && wr_mode_q && (we_rise || ce_rise);
        rd_drive = (state_q == ST_READY) && !ce_s && !oe_s && !wr_mode_q && !wr_done_q;
    end

    // cycle bookkeeping: counters, latched address, write mode, read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt   <= '0;
            pc_cnt    <= PC_MAX;
            wr_mode_q <= 1'b0;
            wr_done_q <= 1'b0;
            ce_up_q   <= 1'b0;
            err_q     <= 1'b0;
            addr_q    <= '0;
            rd_q      <= '0;
        end else begin
            if (ce_fall && state_q != ST_IDLE) err_q <= 1'b1;

            if (ce_rise)               pc_cnt <= PCW'(1);
            else if (pc_cnt != PC_MAX) pc_cnt <= pc_cnt + PCW'(1);

            if (state_q == ST_IDLE && ce_fall) begin
                addr_q    <= addr_s;
                wr_mode_q <= !we_s;
                wr_done_q <= 1'b0;
                ce_up_q   <= 1'b0;
                acc_cnt   <= '0;
            end

            if (state_q == ST_ACCESS) begin
                if (acc_cnt != ACC_LAST) acc_cnt <= acc_cnt + ACW'(1);
                else                     rd_q    <= rd_word;
                if (ce_rise) ce_up_q <= 1'b1;
            end

            if (cyc_open) begin
                if (wr_en) begin
                    wr_mode_q <= 1'b0;
                    wr_done_q <= 1'b1;
                end else if (we_fall) begin
                    wr_mode_q <= 1'b1;
                end
            end
        end
    end

    assign state     = state_q;
    assign lat_addr  = addr_q;
    assign wr_mode   = wr_mode_q;
    assign rd_data   = rd_q;
    assign prech_err = err_q;

endmodule

// File: rtl/latram_ctrl.sv
module latram_ctrl
    import latram_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int ACCESS_CYC  = 4,
    parameter int PRECH_CYC   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en,
    output logic              prech_err
);

    localparam int BUS_W = ADDR_W + DATA_W;

    logic [2:0]        ctl_n_s;
    logic [1:0]        ctl_fall, ctl_rise;
    logic [BUS_W-1:0]  bus_s;
    logic              ce_rise, we_rise;
    cyc_state_e        state;
    logic [ADDR_W-1:0] lat_addr;
    logic              wr_en, wr_mode;
    logic [DATA_W-1:0] rd_word;

    assign ce_rise = ctl_rise[0];
    assign we_rise = ctl_rise[1];

    latram_sync #(
        .STAGES (SYNC_STAGES),
        .BUS_W  (BUS_W)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_n_raw ({oe_n, we_n, ce_n}),
        .bus_raw   ({addr, wdata}),
        .ctl_n_s   (ctl_n_s),
        .ctl_fall  (ctl_fall),
        .ctl_rise  (ctl_rise),
        .bus_s     (bus_s)
    );

    latram_fsm #(
        .AW         (ADDR_W),
        .DW         (DATA_W),
        .ACCESS_CYC (ACCESS_CYC),
        .PRECH_CYC  (PRECH_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_s      (ctl_n_s[0]),
        .ce_fall   (ctl_fall[0]),
        .ce_rise   (ce_rise),
        .we_s      (ctl_n_s[1]),
        .we_fall   (ctl_fall[1]),
        .we_rise   (we_rise),
        .oe_s      (ctl_n_s[2]),
        .addr_s    (bus_s[BUS_W-1:DATA_W]),
        .rd_word   (rd_word),
        .state     (state),
        .lat_addr  (lat_addr),
        .wr_en     (wr_en),
        .wr_mode   (wr_mode),
        .rd_data   (rdata),
        .rd_drive  (rdata_en),
        .prech_err (prech_err)
    );

    latram_array #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (lat_addr),
        .wr_data (bus_s[DATA_W-1:0]),
        .rd_addr (lat_addr),
        .rd_data (rd_word)
    );

endmodule

// File: rtl/latram_checker.sv
module latram_checker
    import latram_pkg::*;
#(
    parameter int AW         = 10,
    parameter int ACCESS_CYC = 4,
    parameter int PRECH_CYC  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          oe_n,
    input logic          rdata_en,
    input logic          prech_err,
    input cyc_state_e    state,
    input logic [AW-1:0] lat_addr,
    input logic          wr_en,
    input logic          wr_mode,
    input logic          we_rise,
    input logic          ce_rise
);

    logic [15:0] acc_run;
    logic [15:0] pc_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_run <= '0;
            pc_run  <= 16'hFFFF;
        end else begin
            acc_run <= (state == ST_ACCESS) ? acc_run + 16'd1 : 16'd0;
            if (ce_rise)                pc_run <= 16'd1;
            else if (pc_run != 16'hFFFF) pc_run <= pc_run + 16'd1;
        end
    end

    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(lat_addr));

    assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |-> !rdata_en);

    assert_commit_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (we_rise || ce_rise));

    assert_access_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS) |-> (acc_run < 16'(ACCESS_CYC)));

    assert_access_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ACCESS && state != ST_ACCESS) |-> (acc_run == 16'(ACCESS_CYC)));

    assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_en |-> !$past(oe_n, 2));

    assert_prech_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_PRECH && state == ST_IDLE) |-> ($past(pc_run) >= 16'(PRECH_CYC - 1)));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prech_err) |-> prech_err);

endmodule

bind latram_ctrl latram_checker #(
    .AW         (ADDR_W),
    .ACCESS_CYC (ACCESS_CYC),
    .PRECH_CYC  (PRECH_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe_n      (oe_n),
    .rdata_en  (rdata_en),
    .prech_err (prech_err),
    .state     (state),
    .lat_addr  (lat_addr),
    .wr_en     (wr_en),
    .wr_mode   (wr_mode),
    .we_rise   (we_rise),
    .ce_rise   (ce_rise)
);

// File: tb/latram_ctrl_bench.sv
module latram_ctrl_bench;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int AC    = 4;
    localparam int PC    = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_en;
    logic          prech_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [DW-1:0] model [DEPTH];

    always #2 clk = ~clk;

    latram_ctrl #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .ACCESS_CYC (AC),
        .PRECH_CYC  (PC)
    ) u_latram_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .rdata_en  (rdata_en),
        .prech_err (prech_err)
    );

    function automatic logic [DW-1:0] pat(int a, int salt);
        return DW'((a * 37 + salt * 11 + 5) & 8'hFF);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // read cycle; leaves exactly PC falling edges of chip-select high time
    task automatic rd_cycle(int a, logic oe, string req);
        ce_n = 1'b0; we_n = 1'b1; oe_n = oe; addr = AW'(a);
        tick(1);
        addr = ~AW'(a);                       // R1: ignored after the latch
        tick(AC + 1);
        chk("R5", rdata_en, 0);
        tick(1);
        if (!oe) begin
            chk("R5", rdata_en, 1);
            chk(req, rdata, model[a]);
        end else begin
            chk("R6", rdata_en, 0);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        tick(PC);
    endtask

    // write with the write strobe already low at the chip-select fall
    task automatic wr_ce(int a, logic [DW-1:0] d);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = AW'(a); wdata = d;
        tick(1);
        addr = ~AW'(a);
        tick(AC + 2);
        chk("R2", rdata_en, 0);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(1);
        wdata = ~d;
        model[a] = d;
        tick(PC - 1);
    endtask

    // write opened as a read, converted by a later write-strobe fall
    task automatic wr_we(int a, logic [DW-1:0] d);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(a); wdata = ~d;
        tick(1);
        addr = ~AW'(a);
        tick(AC + 2);
        chk("R3", rdata_en, 1);
        chk("R3", rdata, model[a]);
        we_n = 1'b0; wdata = d;
        tick(2);
        chk("R3", rdata_en, 1);
        tick(1);
        chk("R3", rdata_en, 0);
        we_n = 1'b1;
        tick(1);
        wdata = ~d;                           // R4: after the commit sample
        tick(2);
        chk("R4", rdata_en, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        model[a] = d;
        tick(PC);
    endtask

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; wdata = '0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        tick(4);
        chk("R11", rdata_en, 0);
        chk("R11", prech_err, 0);
        rst_n = 1'b1;
        tick(2);

        // R10: start-up contents are zero
        rd_cycle(3, 1'b0, "R10");

        // sweep: alternate write styles, read back at minimum precharge spacing
        for (int a = 0; a < DEPTH; a++) begin
            if (a % 2 == 0) wr_ce(a, pat(a, 0));
            else            wr_we(a, pat(a, 0));
            rd_cycle(a, 1'b0, "R9");
        end

        // R6: output enable high never drives
        for (int a = 0; a < DEPTH; a++) rd_cycle(a, 1'b1, "R6");

        // overwrite with the opposite styles, then read with scrambled address
        for (int a = 0; a < DEPTH; a++) begin
            if (a % 2 == 0) wr_we(a, pat(a, 1));
            else            wr_ce(a, pat(a, 1));
        end
        for (int a = 0; a < DEPTH; a++) rd_cycle(a, 1'b0, "R1");
        chk("R8", prech_err, 0);

        // R7: chip select released one clock after its fall during a write
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(5); wdata = 8'hA5;
        tick(1);
        ce_n = 1'b1; we_n = 1'b1; addr = ~AW'(5);
        tick(1);
        wdata = 8'h5A;
        model[5] = 8'hA5;
        tick(AC + PC + 4);
        rd_cycle(5, 1'b0, "R7");

        // R8: fall one clock short of the precharge minimum
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(2);
        tick(AC + 3);
        chk("R5", rdata_en, 1);
        ce_n = 1'b1;
        tick(PC - 1);
        ce_n = 1'b0;
        for (int k = 0; k < AC + 4; k++) begin
            tick(1);
            chk("R8", rdata_en, 0);
        end
        chk("R8", prech_err, 1);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(PC + 1);
        rd_cycle(2, 1'b0, "R8");
        chk("R8", prech_err, 1);

        // R10/R11: reset leaves contents, clears control state
        rst_n = 1'b0;
        tick(3);
        chk("R11", rdata_en, 0);
        chk("R11", prech_err, 0);
        rst_n = 1'b1;
        tick(2);
        rd_cycle(5, 1'b0, "R10");
        rd_cycle(0, 1'b0, "R10");
        rd_cycle(DEPTH - 1, 1'b0, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule